// File: doc/BRIEF.md
# Interrupt priority mask filter

This block holds the priority mask of one processor's interrupt interface and decides whether the pending interrupt presented to it may be signalled. Software reaches the mask through a 64-bit register port. Only the low byte carries state. All other bits read as zero and ignore writes. A lower numeric priority value means a more urgent interrupt. The pending interrupt is signalled only when its priority value is strictly below the mask.

A parameter sets how many high-order priority bits the block implements, from 4 to 8. This gives 16 to 256 levels. The low bits that are not implemented read as zero and drop whatever is written to them. The same truncation is applied to the incoming priority before the compare, so both operands use the same resolution.

A mask write needs no synchronisation step. The compare already uses the written value in the cycle the write is presented. An interrupt that the new mask blocks is therefore never signalled after the write. The filter output is combinational from its inputs and the stored mask.

Top module: `prio_mask_filter`

## Requirements
- R1: After reset the stored mask is 0x00, the read port returns zero, and no interrupt is signalled.
- R2: Read data bits 63:8 are always zero, whatever value has been written to them.
- R3: The low 8-IMPL_BITS bits of the mask read as zero and drop writes. With IMPL_BITS=5, writing 0xFF reads back as 0xF8.
- R4: With valid high, the output is high exactly when the truncated priority is numerically less than the mask. A priority equal to the mask is not signalled.
- R5: In the cycle in which reg_wr_en is high, the compare uses the newly written (truncated) mask and not the old stored one.
- R6: Before the compare, the incoming priority has its unimplemented low bits cleared. With IMPL_BITS=5 and mask 0xF8, priority 0xF7 compares as 0xF0 and is signalled.
- R7: While irq_valid is low, irq_signal is low.
- R8: With no write, the stored mask and the read data keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Mask register write strobe |
| reg_wr_data | input | 64 | Write data; only bits 7:0 are used |
| reg_rd_data | output | 64 | Stored mask, zero-extended |
| irq_valid | input | 1 | A pending interrupt is presented |
| irq_prio | input | 8 | Priority of the pending interrupt |
| irq_signal | output | 1 | Pending interrupt may be signalled |

## Verification
Directed cases place the priority just below the mask, equal to it, and above it. These separate a strict compare from an inclusive one. Priorities whose low bits are set while their high bits match the mask show whether the incoming value is truncated before the compare. Writes that coincide with a pending interrupt show whether the bypass uses the new mask or the old one. An all-ones write shows the reserved and unimplemented bits reading as zero. A long sweep of random writes, priorities and valid flags, compared each cycle against a behavioural model, covers the remaining pairings.

// File: rtl/pmf_pkg.sv
package pmf_pkg;

    localparam int PRIO_W = 8;
    localparam int REG_W  = 64;

    typedef logic [PRIO_W-1:0] prio_t;

    typedef struct packed {
        prio_t mask;
    } pmf_state_t;

    // Keeps the implemented high-order priority bits, clears the rest.
    function automatic prio_t impl_keep(input int bits);
        return prio_t'(8'hFF << (PRIO_W - bits));
    endfunction

endpackage

// File: rtl/pmf_mask_reg.sv
module pmf_mask_reg
    import pmf_pkg::*;
#(
    parameter int IMPL_BITS = 5
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_en,
    input  prio_t wr_val,
    output prio_t mask_q,
    output prio_t eff_mask
);
    localparam prio_t KEEP = impl_keep(IMPL_BITS);

    pmf_state_t state_d, state_q;
    prio_t      wr_trunc;

    always_comb begin
        wr_trunc = wr_val & KEEP;
        state_d  = state_q;
        if (wr_en) begin
            state_d.mask = wr_trunc;
        end
        // Bypass: the compare sees the written value in the write cycle.
        eff_mask = state_d.mask;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign mask_q = state_q.mask;

    // R5: an accepted write lands truncated in the stored mask
    assert_wr_loads_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (mask_q == ($past(wr_val) & KEEP)));

    // R8: no write, no change
    assert_mask_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(mask_q));

endmodule

// File: rtl/pmf_compare.sv
module pmf_compare
    import pmf_pkg::*;
#(
    parameter int IMPL_BITS = 5
) (
    input  logic  valid,
    input  prio_t prio,
    input  prio_t mask,
    output logic  signal
);
    localparam prio_t KEEP = impl_keep(IMPL_BITS);

    prio_t prio_trunc;

    always_comb begin
        prio_trunc = prio & KEEP;
        signal     = valid && (prio_trunc < mask);
    end

endmodule

// File: rtl/prio_mask_filter.sv
module prio_mask_filter
    import pmf_pkg::*;
#(
    parameter int IMPL_BITS = 5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr_en,
    input  logic [63:0] reg_wr_data,
    output logic [63:0] reg_rd_data,
    input  logic        irq_valid,
    input  logic [7:0]  irq_prio,
    output logic        irq_signal
);
    localparam prio_t KEEP = impl_keep(IMPL_BITS);

    prio_t mask_q;
    prio_t eff_mask;
    logic  unused_hi;

    assign unused_hi = ^reg_wr_data[REG_W-1:PRIO_W];

    pmf_mask_reg #(.IMPL_BITS(IMPL_BITS)) u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr_en),
        .wr_val   (reg_wr_data[PRIO_W-1:0]),
        .mask_q   (mask_q),
        .eff_mask (eff_mask)
    );

    pmf_compare #(.IMPL_BITS(IMPL_BITS)) u_cmp (
        .valid  (irq_valid),
        .prio   (irq_prio),
        .mask   (eff_mask),
        .signal (irq_signal)
    );

    assign reg_rd_data = {{(REG_W-PRIO_W){1'b0}}, mask_q};

    // R7: nothing signalled without a pending interrupt
    assert_no_sig_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_valid |-> !irq_signal);

    // R4: a priority at or below the stored mask's urgency is never signalled
    assert_strict_block_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_wr_en && ((irq_prio & KEEP) >= reg_rd_data[7:0])) |-> !irq_signal);

    // R2: reserved read bits stay zero across writes
    assert_rd_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> (reg_rd_data[63:8] == '0));

    generate
        if (IMPL_BITS < PRIO_W) begin : g_low_chk
            // R3: unimplemented low mask bits read as zero
            assert_low_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
                reg_wr_en |=> (reg_rd_data[PRIO_W-1-IMPL_BITS:0] == '0));
        end
    endgenerate

endmodule

// File: tb/sim_prio_mask_filter.sv
module sim_prio_mask_filter;
    localparam int CLK_PERIOD = 10;
    localparam int IMPL       = 5;
    localparam int KEEP       = 256 - (1 << (8 - IMPL));

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [63:0] reg_wr_data = '0;
    logic [63:0] reg_rd_data;
    logic        irq_valid = 1'b0;
    logic [7:0]  irq_prio = '0;
    logic        irq_signal;

    int checks = 0;
    int failures = 0;
    int ref_mask = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    prio_mask_filter #(.IMPL_BITS(IMPL)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr_en   (reg_wr_en),
        .reg_wr_data (reg_wr_data),
        .reg_rd_data (reg_rd_data),
        .irq_valid   (irq_valid),
        .irq_prio    (irq_prio),
        .irq_signal  (irq_signal)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One clock: drive at falling edge, check, then advance the model at the rising edge.
    task automatic step(input bit wr, input logic [63:0] data, input bit v, input int p,
                        input string sig_tag, input string rd_tag);
        int  eff;
        bit  exp_sig;
        logic [63:0] exp_rd;
        @(negedge clk);
        reg_wr_en   = wr;
        reg_wr_data = data;
        irq_valid   = v;
        irq_prio    = p[7:0];
        #1;
        eff     = wr ? (int'(data[7:0]) & KEEP) : ref_mask;
        exp_sig = v && ((p & KEEP) < eff);
        exp_rd  = 64'(ref_mask);
        chk(irq_signal == exp_sig, sig_tag, 64'(irq_signal), 64'(exp_sig));
        chk(reg_rd_data == exp_rd, rd_tag, reg_rd_data, exp_rd);
        @(posedge clk);
        if (wr) ref_mask = int'(data[7:0]) & KEEP;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state, priority 0 is not below mask 0
        step(0, 64'h0, 1, 8'h00, "R1", "R1");
        // R5: write in the same cycle as a pending interrupt uses the new mask
        step(1, 64'hFFFF_FFFF_FFFF_FFFF, 1, 8'hF0, "R5", "R1");
        // R2/R3: all-ones write reads back as 0xF8, upper bits zero
        step(0, 64'h0, 1, 8'hF8, "R4", "R3");
        step(0, 64'h0, 1, 8'hF7, "R6", "R2");
        step(0, 64'h0, 1, 8'hFF, "R4", "R8");
        step(0, 64'h0, 0, 8'h00, "R7", "R8");
        // R5: lowering the mask blocks a less urgent interrupt at once
        step(1, 64'hAAAA_0000_0000_0017, 1, 8'h40, "R5", "R8");
        step(0, 64'h0, 1, 8'h08, "R4", "R3");
        step(0, 64'h0, 1, 8'h0F, "R6", "R8");
        step(0, 64'h0, 1, 8'h10, "R4", "R8");
        step(0, 64'h0, 0, 8'h00, "R7", "R8");
        // R5: raising the mask admits the interrupt in the write cycle
        step(1, 64'h80, 1, 8'h78, "R5", "R8");
        step(0, 64'h0, 1, 8'h80, "R4", "R8");
        for (int i = 0; i < 300; i++) begin
            logic [63:0] d;
            d = {$urandom, $urandom};
            step(($urandom % 4) == 0, d, ($urandom % 5) != 0, int'($urandom % 256), "R4", "R8");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule